// File: doc/BRIEF.md
# Character display command decoder

This block is the bus-facing instruction interface of a character-matrix display controller. A host drives an 8-bit data bus together with a register-select line, a read/write line and an enable strobe. A write is taken on the falling edge of the enable strobe. Depending on the select lines, it is either an instruction or a character byte for the 32-cell character buffer. Reads return either a status byte or the character under the address counter. Reads are combinational while the enable strobe is high.

Each instruction byte is classified by the position of its highest set bit. That class picks the action: clear, return home, entry mode, display control, cursor or display shift, or loading the address counter. Two classes are accepted and have no effect. After every accepted write the block stays busy for a fixed number of clock cycles. Writes that arrive while it is busy are discarded.

After reset, a small sequencer feeds four fixed instructions through the same decode path and then releases busy. This leaves the display blank and switched off, with the entry mode set to increment.

Top module: `chardisp_ctrl`

## Requirements
- R1: With select=0 and read/write=0 a falling enable edge writes an instruction; with select=1 and read/write=0 it writes a character; with read/write=1 the access is a read and changes neither the address counter, the mode outputs nor any cell.
- R2: An instruction is classified by its highest set bit; the byte 0x00 and every byte from 0x20 to 0x7F leave the address counter and all mode outputs unchanged.
- R3: Instruction 0x01 fills all 32 cells with 0x20 and leaves the address counter unchanged.
- R4: Instructions 0x02 and 0x03 set the address counter to 0.
- R5: Instructions 0x04 to 0x07 load entry_inc from bit 1 and entry_shift from bit 0.
- R6: Instructions 0x08 to 0x0F load disp_on from bit 2, cursor_on from bit 1 and blink_on from bit 0.
- R7: Instructions 0x10 to 0x1F load shift_disp from bit 3 and shift_right from bit 2; when bit 3 is 0 the address counter also steps by +1 (bit 2 = 1) or -1 (bit 2 = 0), modulo 32.
- R8: Instructions 0x80 to 0xFF load the 7-bit address counter with bits 6:0 of the byte.
- R9: A character write stores the byte in cell address[4:0] and then sets the address counter to (address[4:0] + 1) mod 32 when entry_inc is 1, or to (address[4:0] - 1) mod 32 when it is 0.
- R10: While enable and read/write are high, bus_dout is {busy, address[6:0]} for select=0 and the content of cell address[4:0] for select=1; otherwise it is 0x00.
- R11: An accepted write holds busy high on the next BUSY_CYCLES clock edges; a write whose falling enable edge meets one of those edges is discarded.
- R12: After reset, busy is high while the block applies 0x01, 0x30, 0x08 and 0x06 on the first four clock edges. After that, busy is low, the address counter is 0, entry_inc is 1, all other mode outputs are 0, and every cell holds 0x20.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_e | input | 1 | Enable strobe; writes are taken on its falling edge |
| bus_rs | input | 1 | Register select: 0 instruction/status, 1 character data |
| bus_rw | input | 1 | 1 for read, 0 for write |
| bus_din | input | 8 | Data bus from the host |
| bus_dout | output | 8 | Read data, valid while enable and read/write are high |
| disp_on | output | 1 | Display enabled |
| cursor_on | output | 1 | Cursor visible |
| blink_on | output | 1 | Cursor blinking |
| entry_inc | output | 1 | Address steps up (1) or down (0) after a character write |
| entry_shift | output | 1 | Display shift on entry enabled |
| shift_disp | output | 1 | Last shift instruction moved the display (1) or the cursor (0) |
| shift_right | output | 1 | Direction of the last shift instruction (1 = right) |

## Verification
The hardest situation to reach from the ports is a second write landing inside the busy window. The window is only BUSY_CYCLES edges long and starts on the edge that detects the first falling strobe. The bench therefore drives two strobe pulses back to back, one clock apart, and checks the dropped instruction through a later status read. The address wrap at both ends of the 32-cell buffer is reached by loading address 0x5F before an incrementing write and address 0 before a decrementing write or cursor move. This also shows that the upper address bits are discarded by the step.

// File: rtl/chardisp_pkg.sv
// Package: shared types and constants for the character display decoder.
// Assumes an 8-bit host bus and a 7-bit address counter.
package chardisp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 7;
    localparam logic [DATA_W-1:0] SPACE_CODE = 8'h20;
    localparam int INIT_LEN = 4;

    // Instruction class, picked by the highest set bit of the byte
    typedef enum logic [3:0] {
        OP_NONE,
        OP_CLEAR,
        OP_HOME,
        OP_ENTRY,
        OP_DCTRL,
        OP_SHIFT,
        OP_FUNC,
        OP_GLYPH,
        OP_SETADDR
    } op_e;

    // One write as seen by the state logic
    typedef struct packed {
        logic              rs;
        logic [DATA_W-1:0] data;
    } cmd_t;

    // Power-up instruction list, applied in index order
    function automatic logic [DATA_W-1:0] init_byte(input logic [1:0] idx);
        case (idx)
            2'd0:    return 8'h01;
            2'd1:    return 8'h30;
            2'd2:    return 8'h08;
            default: return 8'h06;
        endcase
    endfunction

endpackage

// File: rtl/chardisp_decode.sv
// Module: classifies an instruction byte by its highest set bit.
// Assumes nothing about timing; purely combinational.
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic [DATA_W-1:0] instr,
    output op_e               op
);
    localparam int POS_W = $clog2(DATA_W);

    logic             found;
    logic [POS_W-1:0] lead;

    // Find the highest set bit; a later hit overrides a lower one
    always_comb begin
        found = 1'b0;
        lead  = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (instr[i]) begin
                found = 1'b1;
                lead  = POS_W'(i);
            end
        end
    end

    // Map leading-one position to an instruction class
    always_comb begin
        if (!found) begin
            op = OP_NONE;
        end else begin
            case (lead)
                3'd0:    op = OP_CLEAR;
                3'd1:    op = OP_HOME;
                3'd2:    op = OP_ENTRY;
                3'd3:    op = OP_DCTRL;
                3'd4:    op = OP_SHIFT;
                3'd5:    op = OP_FUNC;
                3'd6:    op = OP_GLYPH;
                default: op = OP_SETADDR;
            endcase
        end
    end

    // R2 a nonzero byte always maps to some class
    always_comb begin
        if (instr != '0) begin
            nonzero_class_chk: assert (op != OP_NONE);
        end
    end

endmodule

// File: rtl/chardisp_strobe.sv
// Module: detects the falling enable edge, qualifies writes, and runs
// the busy timer. Assumes bus inputs are synchronous to clk.
module chardisp_strobe #(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_e,
    input  logic bus_rw,
    input  logic hold_busy,
    output logic wr_valid,
    output logic busy
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic             e_q;
    logic [CNT_W-1:0] cnt;
    logic             fall;

    // Edge qualification and busy combination
    always_comb begin
        fall     = e_q & ~bus_e;
        busy     = hold_busy | (cnt != '0);
        wr_valid = fall & ~bus_rw & ~busy;
    end

    // Delayed enable for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= 1'b0;
        else        e_q <= bus_e;
    end

    // Busy timer: reload on an accepted write, count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (wr_valid)       cnt <= CNT_W'(BUSY_CYCLES);
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    // R11
    busy_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> busy);

    // R11
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

endmodule

// File: rtl/chardisp_init.sv
// Module: power-up sequencer that replays a fixed instruction list
// once after reset. Assumes the consumer accepts one command per cycle.
module chardisp_init
    import chardisp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic run,
    output cmd_t cmd
);
    localparam int IDX_W = $clog2(INIT_LEN);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(INIT_LEN - 1);

    logic [IDX_W-1:0] idx;

    // Step through the list, stop after the last entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b1;
            idx <= '0;
        end else if (run) begin
            idx <= idx + 1'b1;
            if (idx == LAST) run <= 1'b0;
        end
    end

    // Present the current list entry as an instruction write
    always_comb begin
        cmd.rs   = 1'b0;
        cmd.data = init_byte(idx);
    end

    // R12
    init_ends_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && idx != LAST) |=> run);

    // R12
    init_stays_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !run);

endmodule

// File: rtl/chardisp_state.sv
// Module: address counter, mode bits and the character buffer.
// Assumes one qualified command per cycle; op is the decoded class
// of cmd.data and is only used when cmd.rs is 0.
module chardisp_state
    import chardisp_pkg::*;
#(
    parameter int CELLS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_t              cmd,
    input  op_e               op,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] cell_q,
    output logic              disp_on,
    output logic              cursor_on,
    output logic              blink_on,
    output logic              entry_inc,
    output logic              entry_shift,
    output logic              shift_disp,
    output logic              shift_right
);
    localparam int IDX_W = $clog2(CELLS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELLS - 1);

    logic [DATA_W-1:0] cells [CELLS];
    logic [IDX_W-1:0]  cur_idx;
    logic [6:0]        mode_bits;

    // Cyclic step of the cell index, widened back to the counter
    function automatic logic [ADDR_W-1:0] step(input logic [IDX_W-1:0] i, input logic up);
        logic [IDX_W-1:0] n;
        if (up) n = (i == LAST_IDX) ? '0 : i + 1'b1;
        else    n = (i == '0) ? LAST_IDX : i - 1'b1;
        return ADDR_W'(n);
    endfunction

    // Current cell index, read data and mode bundle
    always_comb begin
        cur_idx   = addr[IDX_W-1:0];
        cell_q    = cells[cur_idx];
        mode_bits = {disp_on, cursor_on, blink_on, entry_inc,
                     entry_shift, shift_disp, shift_right};
    end

    // Address counter and mode bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr        <= '0;
            disp_on     <= 1'b0;
            cursor_on   <= 1'b0;
            blink_on    <= 1'b0;
            entry_inc   <= 1'b0;
            entry_shift <= 1'b0;
            shift_disp  <= 1'b0;
            shift_right <= 1'b0;
        end else if (cmd_valid) begin
            if (cmd.rs) begin
                addr <= step(cur_idx, entry_inc);
            end else begin
                case (op)
                    OP_HOME: addr <= '0;
                    OP_ENTRY: begin
                        entry_inc   <= cmd.data[1];
                        entry_shift <= cmd.data[0];
                    end
                    OP_DCTRL: begin
                        disp_on   <= cmd.data[2];
                        cursor_on <= cmd.data[1];
                        blink_on  <= cmd.data[0];
                    end
                    OP_SHIFT: begin
                        shift_disp  <= cmd.data[3];
                        shift_right <= cmd.data[2];
                        if (!cmd.data[3]) addr <= step(cur_idx, cmd.data[2]);
                    end
                    OP_SETADDR: addr <= cmd.data[ADDR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Character buffer: indexed store or fill with spaces
    always_ff @(posedge clk) begin
        if (rst_n && cmd_valid) begin
            if (cmd.rs) begin
                cells[cur_idx] <= cmd.data;
            end else if (op == OP_CLEAR) begin
                for (int c = 0; c < CELLS; c++) cells[c] <= SPACE_CODE;
            end
        end
    end

    // R1
    idle_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(addr) && $stable(mode_bits)));

    // R2
    ignored_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd.rs && (op == OP_NONE || op == OP_FUNC || op == OP_GLYPH))
        |=> ($stable(addr) && $stable(mode_bits)));

    // R3
    clear_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd.rs && op == OP_CLEAR) |=> $stable(addr));

    // R8
    load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd.rs && op == OP_SETADDR) |=> addr == $past(cmd.data[ADDR_W-1:0]));

    // R9
    wrap_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd.rs && entry_inc && cur_idx == LAST_IDX) |=> addr == '0);

endmodule

// File: rtl/chardisp_ctrl.sv
// Module: top of the character display command decoder. Muxes the
// power-up sequencer and the host bus into one command path and
// drives the read bus. Assumes bus inputs are synchronous to clk.
module chardisp_ctrl
    import chardisp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int CELLS       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_e,
    input  logic              bus_rs,
    input  logic              bus_rw,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              disp_on,
    output logic              cursor_on,
    output logic              blink_on,
    output logic              entry_inc,
    output logic              entry_shift,
    output logic              shift_disp,
    output logic              shift_right
);
    logic              init_run;
    cmd_t              init_cmd;
    logic              wr_valid;
    logic              busy;
    logic              cmd_valid;
    cmd_t              cmd;
    op_e               op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] cell_q;

    chardisp_init u_init (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (init_run),
        .cmd   (init_cmd)
    );

    chardisp_strobe #(.BUSY_CYCLES(BUSY_CYCLES)) u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_e     (bus_e),
        .bus_rw    (bus_rw),
        .hold_busy (init_run),
        .wr_valid  (wr_valid),
        .busy      (busy)
    );

    // Command source select: sequencer first, host otherwise
    always_comb begin
        cmd_valid = rst_n & (init_run | wr_valid);
        if (init_run) begin
            cmd = init_cmd;
        end else begin
            cmd.rs   = bus_rs;
            cmd.data = bus_din;
        end
    end

    chardisp_decode u_decode (
        .instr (cmd.data),
        .op    (op)
    );

    chardisp_state #(.CELLS(CELLS)) u_state (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .op          (op),
        .addr        (addr),
        .cell_q      (cell_q),
        .disp_on     (disp_on),
        .cursor_on   (cursor_on),
        .blink_on    (blink_on),
        .entry_inc   (entry_inc),
        .entry_shift (entry_shift),
        .shift_disp  (shift_disp),
        .shift_right (shift_right)
    );

    // Read bus: status or character under the counter
    always_comb begin
        if (bus_e && bus_rw) bus_dout = bus_rs ? cell_q : {busy, addr};
        else                 bus_dout = '0;
    end

    // R10
    init_reads_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_run && bus_e && bus_rw && !bus_rs) |-> bus_dout[DATA_W-1]);

    // R10
    idle_bus_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_e |-> bus_dout == '0);

endmodule

// File: tb/chardisp_ctrl_test.sv
module chardisp_ctrl_test;
    localparam int CLK_PERIOD  = 10;
    localparam int BUSY_CYCLES = 4;
    localparam int NVEC        = 18;

    typedef struct packed {
        logic       rs;
        logic [7:0] din;
        logic [7:0] st;
        logic [6:0] fl;
        logic [3:0] req;
    } vec_t;

    // flags order: disp, cursor, blink, inc, eshift, sdisp, sright
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 8'h0F, 8'h00, 7'b1111000, 4'd6},  // R6 all on
        '{1'b0, 8'h85, 8'h05, 7'b1111000, 4'd8},  // R8 load address
        '{1'b1, 8'h41, 8'h06, 7'b1111000, 4'd9},  // R9 write, step up
        '{1'b0, 8'h04, 8'h06, 7'b1110000, 4'd5},  // R5 decrement
        '{1'b1, 8'h42, 8'h05, 7'b1110000, 4'd9},  // R9 write, step down
        '{1'b0, 8'h14, 8'h06, 7'b1110001, 4'd7},  // R7 cursor right
        '{1'b0, 8'h18, 8'h06, 7'b1110010, 4'd7},  // R7 display shift left
        '{1'b0, 8'h3C, 8'h06, 7'b1110010, 4'd2},  // R2 ignored class
        '{1'b0, 8'h55, 8'h06, 7'b1110010, 4'd2},  // R2 ignored class
        '{1'b0, 8'h07, 8'h06, 7'b1111110, 4'd5},  // R5 inc + shift
        '{1'b0, 8'h0A, 8'h06, 7'b0101110, 4'd6},  // R6 cursor only
        '{1'b0, 8'hDF, 8'h5F, 7'b0101110, 4'd8},  // R8 high bits kept
        '{1'b1, 8'h43, 8'h00, 7'b0101110, 4'd9},  // R9 wrap 31 -> 0
        '{1'b0, 8'h05, 8'h00, 7'b0100110, 4'd5},  // R5 decrement + shift
        '{1'b1, 8'h44, 8'h1F, 7'b0100110, 4'd9},  // R9 wrap 0 -> 31
        '{1'b0, 8'h03, 8'h00, 7'b0100110, 4'd4},  // R4 home
        '{1'b0, 8'h10, 8'h1F, 7'b0100100, 4'd7},  // R7 cursor left wraps
        '{1'b0, 8'h00, 8'h1F, 7'b0100100, 4'd2}   // R2 zero byte
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_e = 1'b0;
    logic       bus_rs = 1'b0;
    logic       bus_rw = 1'b0;
    logic [7:0] bus_din = 8'h00;
    logic [7:0] bus_dout;
    logic       disp_on, cursor_on, blink_on, entry_inc, entry_shift, shift_disp, shift_right;
    logic [6:0] flags;

    int n_chk  = 0;
    int n_fail = 0;

    assign flags = {disp_on, cursor_on, blink_on, entry_inc, entry_shift, shift_disp, shift_right};

    always #(CLK_PERIOD/2) clk = ~clk;

    chardisp_ctrl #(.BUSY_CYCLES(BUSY_CYCLES)) uut (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rs(bus_rs), .bus_rw(bus_rw),
        .bus_din(bus_din), .bus_dout(bus_dout), .disp_on(disp_on), .cursor_on(cursor_on),
        .blink_on(blink_on), .entry_inc(entry_inc), .entry_shift(entry_shift),
        .shift_disp(shift_disp), .shift_right(shift_right)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic rs, input logic [7:0] d);
        @(negedge clk); bus_rs = rs; bus_rw = 1'b0; bus_din = d; bus_e = 1'b1;
        @(negedge clk); bus_e = 1'b0;
        repeat (BUSY_CYCLES + 2) @(negedge clk);
    endtask

    task automatic do_read(input logic rs, output logic [7:0] v);
        @(negedge clk); bus_rs = rs; bus_rw = 1'b1; bus_e = 1'b1;
        #1 v = bus_dout;
        @(negedge clk); bus_e = 1'b0;
        @(negedge clk); bus_rw = 1'b0;
    endtask

    task automatic read_cell(input logic [6:0] a, output logic [7:0] v);
        do_write(1'b0, {1'b1, a});
        do_read(1'b1, v);
    endtask

    task automatic apply_reset_and_check(input string tag);
        logic [7:0] v;
        @(negedge clk); rst_n = 1'b0; bus_e = 1'b0; bus_rw = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; bus_rs = 1'b0; bus_rw = 1'b1; bus_e = 1'b1;
        #1 check({tag, " R12 busy during init"}, bus_dout, 8'h80);
        @(negedge clk); bus_e = 1'b0;
        @(negedge clk); bus_rw = 1'b0;
        repeat (6) @(negedge clk);
        do_read(1'b0, v);
        check({tag, " R12 status after init"}, v, 8'h00);
        check({tag, " R12 modes after init"}, {1'b0, flags}, 8'h08);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] bad;
        logic [7:0] s0;

        apply_reset_and_check("power-up");
        read_cell(7'h0A, v);
        check("R12 cell cleared by init", v, 8'h20);
        do_write(1'b0, 8'h80);

        // Vector walk
        for (int i = 0; i < NVEC; i++) begin
            do_write(VECS[i].rs, VECS[i].din);
            do_read(1'b0, v);
            n_chk++;
            if (v !== VECS[i].st || flags !== VECS[i].fl) begin
                n_fail++;
                $display("FAIL R%0d vec %0d: got st=%02h fl=%07b expected st=%02h fl=%07b",
                         VECS[i].req, i, v, flags, VECS[i].st, VECS[i].fl);
            end
        end

        // R9 / R10 stored characters read back
        read_cell(7'h05, v); check("R9 cell 5", v, 8'h41);
        read_cell(7'h06, v); check("R9 cell 6", v, 8'h42);
        read_cell(7'h1F, v); check("R9 cell 31", v, 8'h43);
        read_cell(7'h00, v); check("R9 cell 0", v, 8'h44);
        // R10 cell picked by low five address bits
        read_cell(7'h25, v); check("R10 index by addr[4:0]", v, 8'h41);

        // R1 reads change nothing
        do_read(1'b1, v);
        do_read(1'b1, v);
        do_read(1'b0, v); check("R1 read keeps address", v, 8'h25);
        check("R1 read keeps modes", {1'b0, flags}, 8'h24);

        // R10 idle bus
        @(negedge clk); #1 check("R10 idle dout", bus_dout, 8'h00);

        // R3 clear keeps address and blanks every cell
        do_write(1'b0, 8'h01);
        do_read(1'b0, v); check("R3 clear keeps address", v, 8'h25);
        bad = 8'h00;
        for (int c = 0; c < 32; c++) begin
            read_cell(7'(c), v);
            if (v !== 8'h20) bad = bad + 8'h01;
        end
        check("R3 non-space cells after clear", bad, 8'h00);

        // R11 busy visible right after a write
        @(negedge clk); bus_rs = 1'b0; bus_rw = 1'b0; bus_din = 8'h81; bus_e = 1'b1;
        @(negedge clk); bus_e = 1'b0;
        @(negedge clk); bus_rw = 1'b1; bus_e = 1'b1;
        #1 check("R11 busy flag set", bus_dout, 8'h81);
        @(negedge clk); bus_e = 1'b0;
        @(negedge clk); bus_rw = 1'b0;
        repeat (BUSY_CYCLES + 2) @(negedge clk);
        do_read(1'b0, v); check("R11 busy cleared", v, 8'h01);

        // R11 write inside busy window dropped
        @(negedge clk); bus_rs = 1'b0; bus_rw = 1'b0; bus_din = 8'h83; bus_e = 1'b1;
        @(negedge clk); bus_e = 1'b0;
        @(negedge clk); bus_din = 8'h8A; bus_e = 1'b1;
        @(negedge clk); bus_e = 1'b0;
        repeat (BUSY_CYCLES + 2) @(negedge clk);
        do_read(1'b0, v); check("R11 second write dropped", v, 8'h03);

        // R12 reset mid-run restores defaults and blanks the buffer
        do_write(1'b0, 8'h0F);
        do_write(1'b0, 8'h85);
        do_write(1'b1, 8'h5A);
        read_cell(7'h05, s0); check("R9 cell before reset", s0, 8'h5A);
        apply_reset_and_check("mid-run");
        read_cell(7'h05, v); check("R12 cell cleared by reset", v, 8'h20);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule